// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a binary up-counter built from identical 4-bit slices. Every state change takes place on the rising clock edge. An active-low clear zeroes the count and an active-low load copies a data word into it. The counter advances by one only when two enables are both high. The first is a parallel enable that every slice shares. The second is a carry enable that passes from slice to slice.

Each slice raises a terminal flag when its own value is all ones and its carry enable is high. That flag feeds the carry enable of the next slice, so a chain of N slices counts as one 4·N-bit binary counter. The flag of the last slice is brought out so that further counters can be cascaded after it.

An optional modulus parameter decodes the count one below the modulus and turns it into a synchronous clear on the following edge. This gives a glitch-free count of 0 to modulus−1. Every interface pin is a plain control or data level. There is no streamed data path, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `sync_count_chain`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `count` becomes 0 after that edge, whatever the levels of `load_n`, `cnt_en` and `carry_en`.
- R2: When `clr_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `load_val` after that edge, whatever the levels of both enables.
- R3: When `clr_n`, `load_n`, `cnt_en` and `carry_en` are all 1 at a rising edge, `count` increases by exactly one.
- R4: When `clr_n` and `load_n` are 1 and either `cnt_en` or `carry_en` is 0, `count` keeps its value across the edge.
- R5: When the count is all ones and it increments, it wraps to 0.
- R6: `term` is 1 exactly when `carry_en` is 1 and `count` is all ones. It follows a change of `carry_en` in the same cycle, with no clock edge in between.
- R7: With NSLICE slices, slice k advances only when every lower slice is all ones and the count is enabled. The chain as a whole matches a 4·NSLICE-bit binary counter.
- R8: With MODULUS > 0, a count equal to MODULUS−1 forces `count` to 0 at the next edge, and this takes priority over load and the enables. With MODULUS = 0 there is no forced clear.
- R9: The sequence clear, load 12, six enabled edges, then inhibit yields 0, 12, 13, 14, 15, 0, 1, 2, and then 2 held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Parallel count enable, shared by every slice |
| carry_en | input | 1 | Carry count enable into the lowest slice; also gates `term` |
| load_val | input | 4·NSLICE | Value copied into the count on a load |
| count | output | 4·NSLICE | Current count |
| term | output | 1 | Terminal flag: `carry_en` high and count all ones |

## Verification
Clear, load, count, hold and the modulus clear act at the first rising edge after the inputs are set. The bench therefore drives its inputs on the falling edge and compares `count` with its model at the next falling edge, half a period after the edge that caused the update. `term` is combinational, so it is compared 1 ns after the inputs change, before any edge can act. Directed steps look at literal values just after the edge.

// File: rtl/sync_count_pkg.sv
package sync_count_pkg;
  localparam int SLICE_W = 4;

  function automatic int chain_width(input int slices);
    return slices * SLICE_W;
  endfunction
endpackage

// File: rtl/count_slice.sv
module count_slice
  import sync_count_pkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         par_en,
  input  logic         chain_in,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         chain_out
);
  always_ff @(posedge clk) begin
    if (!clr_n)                  q <= '0;
    else if (!load_n)            q <= din;
    else if (par_en && chain_in) q <= q + W'(1);
  end

  assign chain_out = chain_in & (&q);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  // R1
  a_r1_clear_wins: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (q == '0));
  // R2
  a_r2_load_wins: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n) |=> (q == $past(din)));
  // R3
  a_r3_step_one: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && par_en && chain_in) |=> (q == W'($past(q) + W'(1))));
  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && !(par_en && chain_in)) |=> $stable(q));
  // R5
  a_r5_wrap: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && par_en && chain_in && (&q)) |=> (q == '0));
endmodule

// File: rtl/wrap_decode.sv
module wrap_decode #(
  parameter int W       = 4,
  parameter int MODULUS = 0
) (
  input  logic [W-1:0] value,
  output logic         hit
);
  generate
    if (MODULUS == 0) begin : g_off
      assign hit = 1'b0;
    end else begin : g_on
      localparam logic [W-1:0] LAST = W'(MODULUS - 1);
      assign hit = (value == LAST);
    end
  endgenerate
endmodule

// File: rtl/sync_count_chain.sv
module sync_count_chain
  import sync_count_pkg::*;
#(
  parameter int NSLICE  = 1,
  parameter int MODULUS = 0
) (
  input  logic                          clk,
  input  logic                          clr_n,
  input  logic                          load_n,
  input  logic                          cnt_en,
  input  logic                          carry_en,
  input  logic [NSLICE*SLICE_W-1:0]     load_val,
  output logic [NSLICE*SLICE_W-1:0]     count,
  output logic                          term
);
  localparam int W = chain_width(NSLICE);

  logic          wrap_hit;
  logic          slice_clr_n;
  logic [NSLICE:0] carry;

  wrap_decode #(.W(W), .MODULUS(MODULUS)) u_wrap (
    .value (count),
    .hit   (wrap_hit)
  );

  assign slice_clr_n = clr_n & ~wrap_hit;
  assign carry[0]    = carry_en;

  generate
    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
      count_slice #(.W(SLICE_W)) u_slice (
        .clk       (clk),
        .clr_n     (slice_clr_n),
        .load_n    (load_n),
        .par_en    (cnt_en),
        .chain_in  (carry[k]),
        .din       (load_val[k*SLICE_W +: SLICE_W]),
        .q         (count[k*SLICE_W +: SLICE_W]),
        .chain_out (carry[k+1])
      );
    end
  endgenerate

  assign term = carry[NSLICE];

  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  // R6
  a_r6_term_flag: assert property (@(posedge clk) disable iff (!armed)
    term == (carry_en && (&count)));

  generate
    if (MODULUS > 0) begin : g_mod_chk
      // R8
      a_r8_mod_clear: assert property (@(posedge clk) disable iff (!armed)
        (count == W'(MODULUS - 1)) |=> (count == '0));
    end
    if (NSLICE > 1) begin : g_chain_chk
      // R7
      a_r7_upper_waits: assert property (@(posedge clk) disable iff (!armed)
        (slice_clr_n && load_n && !(&count[SLICE_W-1:0]))
          |=> $stable(count[W-1:SLICE_W]));
    end
  endgenerate
endmodule

// File: tb/sync_count_chain_tb.sv
module sync_count_chain_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        clr_n = 1'b0, load_n = 1'b1, cnt_en = 1'b0, carry_en = 1'b0;
  logic [11:0] load_val = '0;
  logic [3:0]  cnt_a, cnt_m5, cnt_m11;
  logic [11:0] cnt_w;
  logic        term_a, term_m5, term_m11, term_w;

  sync_count_chain #(.NSLICE(1), .MODULUS(0)) u_dut (
    .clk, .clr_n, .load_n, .cnt_en, .carry_en,
    .load_val(load_val[3:0]), .count(cnt_a), .term(term_a));
  sync_count_chain #(.NSLICE(3), .MODULUS(0)) u_wide (
    .clk, .clr_n, .load_n, .cnt_en, .carry_en,
    .load_val(load_val), .count(cnt_w), .term(term_w));
  sync_count_chain #(.NSLICE(1), .MODULUS(5)) u_mod5 (
    .clk, .clr_n, .load_n, .cnt_en, .carry_en,
    .load_val(load_val[3:0]), .count(cnt_m5), .term(term_m5));
  sync_count_chain #(.NSLICE(1), .MODULUS(11)) u_mod11 (
    .clk, .clr_n, .load_n, .cnt_en, .carry_en,
    .load_val(load_val[3:0]), .count(cnt_m11), .term(term_m11));

  int checks = 0, fails = 0;
  int ea = 0, ew = 0, e5 = 0, e11 = 0;
  bit  model_ok = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nx(input int cur, input int w, input int m);
    int mask = (1 << w) - 1;
    if (!clr_n || (m != 0 && cur == m - 1)) return 0;
    if (!load_n) return int'(load_val) & mask;
    if (cnt_en && carry_en) return (cur + 1) & mask;
    return cur;
  endfunction

  function automatic int tflag(input int cur, input int w);
    return (carry_en && cur == (1 << w) - 1) ? 1 : 0;
  endfunction

  // One cycle: compare state, apply new inputs, check combinational flag, advance model.
  task automatic step(input bit c, input bit l, input bit pe, input bit te, input int d);
    @(negedge clk);
    if (model_ok) begin
      chk("R1-R5 count", cnt_a, ea);
      chk("R7 wide count", cnt_w, ew);
      chk("R8 mod5 count", cnt_m5, e5);
      chk("R8 mod11 count", cnt_m11, e11);
    end
    clr_n = c; load_n = l; cnt_en = pe; carry_en = te; load_val = 12'(d);
    #1;
    if (model_ok) begin
      chk("R6 term", term_a, tflag(ea, 4));
      chk("R6 wide term", term_w, tflag(ew, 12));
      chk("R6 mod5 term", term_m5, tflag(e5, 4));
      chk("R6 mod11 term", term_m11, tflag(e11, 4));
    end
    if (!c) model_ok = 1'b1;
    ea = nx(ea, 4, 0); ew = nx(ew, 12, 0); e5 = nx(e5, 4, 5); e11 = nx(e11, 4, 11);
  endtask

  task automatic after_edge();
    @(posedge clk); #2;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: clear with load and enables active
    step(0, 0, 1, 1, 9); after_edge();
    chk("R1 reset state", cnt_a, 0);
    chk("R1 wide reset state", cnt_w, 0);

    // R9 reference sequence
    step(0, 1, 1, 1, 0); after_edge(); chk("R9 clear", cnt_a, 0);
    step(1, 0, 0, 0, 12); after_edge(); chk("R9/R2 load 12 with enables low", cnt_a, 12);
    step(1, 1, 1, 1, 0); after_edge(); chk("R9/R3 13", cnt_a, 13);
    step(1, 1, 1, 1, 0); after_edge(); chk("R9 14", cnt_a, 14);
    step(1, 1, 1, 1, 0); after_edge(); chk("R9 15", cnt_a, 15);
    chk("R6 term at 15", term_a, 1);
    step(1, 1, 1, 1, 0); after_edge(); chk("R9/R5 wrap to 0", cnt_a, 0);
    step(1, 1, 1, 1, 0); after_edge(); chk("R9 1", cnt_a, 1);
    step(1, 1, 1, 1, 0); after_edge(); chk("R9 2", cnt_a, 2);
    step(1, 1, 0, 1, 0); after_edge(); chk("R9/R4 inhibit hold", cnt_a, 2);
    step(1, 1, 1, 0, 0); after_edge(); chk("R4 carry_en low hold", cnt_a, 2);

    // R6: flag gated combinationally by carry_en, R4 hold at 15
    step(1, 0, 1, 1, 15); after_edge(); chk("R2 load 15", cnt_a, 15);
    step(1, 1, 1, 0, 0); chk("R6 term low with carry_en low", term_a, 0);
    after_edge(); chk("R4 hold at 15", cnt_a, 15);

    // R7: carry across slices
    step(1, 0, 0, 0, 12'h0FF); after_edge(); chk("R7 load 0x0FF", cnt_w, 12'h0FF);
    step(1, 1, 1, 1, 0); after_edge(); chk("R7 carry into slice 2", cnt_w, 12'h100);
    step(1, 0, 1, 1, 12'hFFF); after_edge(); chk("R7 load all ones", cnt_w, 12'hFFF);
    chk("R7 wide term", term_w, 1);
    step(1, 1, 1, 1, 0); after_edge(); chk("R7/R5 wide wrap", cnt_w, 0);

    // R8: modulus sequences
    step(0, 1, 1, 1, 0);
    for (int i = 1; i <= 11; i++) begin
      step(1, 1, 1, 1, 0); after_edge();
      chk("R8 mod5 sequence", cnt_m5, i % 5);
      chk("R8 mod11 sequence", cnt_m11, i % 11);
    end
    // R8: forced clear beats load (mod5 now at 1)
    step(1, 1, 1, 1, 0); step(1, 1, 1, 1, 0); step(1, 1, 1, 1, 0);
    after_edge(); chk("R8 mod5 at 4", cnt_m5, 4);
    step(1, 0, 1, 1, 7); after_edge(); chk("R8 clear beats load", cnt_m5, 0);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 100) >= 3, ($urandom % 100) >= 8,
           ($urandom % 100) < 85, ($urandom % 100) < 85, int'($urandom % 4096));
    end
    step(1, 1, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule